// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the six condition and control flags of an 8-bit processor: negative (N), overflow (V), decimal (D), interrupt mask (I), zero (Z) and carry (C). The execution unit hands it a result byte, a carry-out, a signed-overflow bit and a bit-test operand. It also supplies one write enable per arithmetic flag. Flags whose enable is low keep their value. Single-cycle set and clear strobes let control instructions change C, I, D and V directly.

When the core saves status on the stack, the block forms the byte to write. Bit 5 of that byte is always 1. Bit 4 tells a software push from a hardware interrupt push, and nothing in the register holds it. Hardware pushes and the break push also raise the interrupt mask. When status is pulled back, the six real flags are loaded and the two pseudo-bits are dropped. The block also gates the maskable request with I, passes the non-maskable request through, and drives a decimal-mode line to the arithmetic unit when the `DEC_EN` parameter allows it.

The flag register is the only state. Its transitions are chosen by one priority order: pull, then hardware mask-raise, then set/clear strobes, then ALU loads, then hold.

Top module: `psr_core`

## Requirements
- R1: Reset loads N=V=D=Z=C=0 and I=1. `flags_o` shows the byte as N,V,1,1,D,I,Z,C from bit 7 down to bit 0, so it reads 0x34 after reset.
- R2: `push_byte_o` holds the current N, V, D, I, Z, C in bits 7, 6, 3, 2, 1, 0, with bit 5 always 1. Bit 4 is 1 for `push_src_i` codes 0 (push-status instruction) and 1 (software break). It is 0 for codes 2 (maskable interrupt) and 3 (non-maskable interrupt).
- R3: A push with source code 1, 2 or 3 sets I to 1 in the next cycle, and this wins over `clr_i_i`. A push with code 0 changes no flag.
- R4: `pull_i` loads N, V, D, I, Z, C from `pull_byte_i` bits 7, 6, 3, 2, 1, 0 in the next cycle. Bits 5 and 4 of the pulled byte are ignored. A pull overrides every other update in the same cycle.
- R5: `irq_take_o` is `irq_req_i` AND NOT I, combinationally. `nmi_take_o` equals `nmi_req_i` whatever the value of I.
- R6: With `upd_n_i` high, N takes `res_i[7]`. With `upd_z_i` high, Z is 1 exactly when `res_i` is zero. With `bit_mode_i` high, N takes `opnd_i[7]` and V takes `opnd_i[6]` instead.
- R7: `upd_c_i` loads C from `carry_i` (carry-out, or no-borrow on subtraction). `upd_v_i` loads V from `ovf_i` when not in bit mode. A flag with no active update holds its value.
- R8: The set and clear strobes for C, I, D and the clear strobe for V take effect in the next cycle and override an ALU load of the same flag. When set and clear arrive together, set wins.
- R9: D is stored and read back like any other flag. `dec_mode_o` follows D when `DEC_EN` is 1 and is held at 0 when `DEC_EN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_i | input | 8 | ALU result byte |
| opnd_i | input | 8 | Memory operand for bit test |
| carry_i | input | 1 | Carry-out / no-borrow |
| ovf_i | input | 1 | Signed overflow |
| bit_mode_i | input | 1 | N and V come from the operand |
| upd_n_i | input | 1 | Load N |
| upd_v_i | input | 1 | Load V |
| upd_z_i | input | 1 | Load Z |
| upd_c_i | input | 1 | Load C |
| set_c_i | input | 1 | Set carry |
| clr_c_i | input | 1 | Clear carry |
| set_i_i | input | 1 | Set interrupt mask |
| clr_i_i | input | 1 | Clear interrupt mask |
| set_d_i | input | 1 | Set decimal |
| clr_d_i | input | 1 | Clear decimal |
| clr_v_i | input | 1 | Clear overflow |
| push_i | input | 1 | Status is being pushed |
| push_src_i | input | 2 | Push source code (0..3, see R2) |
| push_byte_o | output | 8 | Byte to write to the stack |
| pull_i | input | 1 | Status is being pulled |
| pull_byte_i | input | 8 | Byte read from the stack |
| irq_req_i | input | 1 | Maskable request |
| nmi_req_i | input | 1 | Non-maskable request |
| irq_take_o | output | 1 | Maskable request passes the mask |
| nmi_take_o | output | 1 | Non-maskable request passes |
| dec_mode_o | output | 1 | Decimal arithmetic enable |
| flags_o | output | 8 | Packed flags, bits 5:4 read 1 |

## Verification
The bench targets four corner cases.

- Pulled bytes that carry 0 or 1 in bits 5 and 4. A design that stored those bits would show them in `flags_o`.
- The bit-4 polarity for all four push sources. Swapping hardware and software codes would break the way a handler tells a break from a real interrupt.
- A clear-mask strobe in the same cycle as a hardware push. Getting this wrong would leave interrupts open inside the handler.
- A pull that coincides with ALU loads. Wrong priority would let stale arithmetic results overwrite the restored flags.

A reference model is compared against all outputs every cycle. Each flag is then checked to keep its value when nothing targets it.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int BYTE_W = 8;

    // bit positions inside the status byte; the stack image depends on them
    localparam int POS_N  = 7;
    localparam int POS_V  = 6;
    localparam int POS_U  = 5;
    localparam int POS_B  = 4;
    localparam int POS_D  = 3;
    localparam int POS_I  = 2;
    localparam int POS_Z  = 1;
    localparam int POS_C  = 0;

    typedef enum logic [1:0] {
        SRC_PUSH_INSN = 2'd0,
        SRC_BREAK     = 2'd1,
        SRC_MASKABLE  = 2'd2,
        SRC_NONMASK   = 2'd3
    } push_src_e;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{n: 1'b0, v: 1'b0, d: 1'b0,
                                       i: 1'b1, z: 1'b0, c: 1'b0};

    function automatic logic [BYTE_W-1:0] pack_flags(flags_t f, logic b_bit);
        logic [BYTE_W-1:0] r;
        r        = '0;
        r[POS_N] = f.n;
        r[POS_V] = f.v;
        r[POS_U] = 1'b1;
        r[POS_B] = b_bit;
        r[POS_D] = f.d;
        r[POS_I] = f.i;
        r[POS_Z] = f.z;
        r[POS_C] = f.c;
        return r;
    endfunction

    function automatic flags_t unpack_flags(logic [BYTE_W-1:0] b);
        flags_t f;
        f.n = b[POS_N];
        f.v = b[POS_V];
        f.d = b[POS_D];
        f.i = b[POS_I];
        f.z = b[POS_Z];
        f.c = b[POS_C];
        return f;
    endfunction

endpackage

// File: rtl/psr_next.sv
module psr_next
    import psr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  flags_t            cur,
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] opnd,
    input  logic              carry,
    input  logic              ovf,
    input  logic              bit_mode,
    input  logic              upd_n,
    input  logic              upd_v,
    input  logic              upd_z,
    input  logic              upd_c,
    input  logic              set_c,
    input  logic              clr_c,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic              set_d,
    input  logic              clr_d,
    input  logic              clr_v,
    input  logic              push,
    input  push_src_e         push_src,
    input  logic              pull,
    input  logic [BYTE_W-1:0] pull_byte,
    output flags_t            nxt
);

    localparam int SIGN_BIT = DATA_W - 1;
    localparam int SUB_BIT  = DATA_W - 2;

    typedef enum logic [2:0] {
        UPD_HOLD,
        UPD_ALU,
        UPD_STROBE,
        UPD_HW_MASK,
        UPD_PULL
    } upd_kind_e;

    upd_kind_e kind;
    flags_t    alu_f;
    flags_t    strobe_f;
    logic      hw_push;
    logic      any_alu;
    logic      any_strobe;

    assign hw_push    = push && (push_src != SRC_PUSH_INSN);
    assign any_alu    = upd_n | upd_v | upd_z | upd_c;
    assign any_strobe = set_c | clr_c | set_i | clr_i | set_d | clr_d | clr_v;

    // classification of the cycle, highest priority first
    always_comb begin
        if (pull)
            kind = UPD_PULL;
        else if (hw_push)
            kind = UPD_HW_MASK;
        else if (any_strobe)
            kind = UPD_STROBE;
        else if (any_alu)
            kind = UPD_ALU;
        else
            kind = UPD_HOLD;
    end

    // ALU-sourced loads on top of the held value
    always_comb begin
        alu_f = cur;
        if (upd_n) alu_f.n = bit_mode ? opnd[SIGN_BIT] : res[SIGN_BIT];
        if (upd_v) alu_f.v = bit_mode ? opnd[SUB_BIT]  : ovf;
        if (upd_z) alu_f.z = (res == '0);
        if (upd_c) alu_f.c = carry;
    end

    // strobes override ALU loads; set beats clear
    always_comb begin
        strobe_f = alu_f;
        if (clr_c) strobe_f.c = 1'b0;
        if (set_c) strobe_f.c = 1'b1;
        if (clr_i) strobe_f.i = 1'b0;
        if (set_i) strobe_f.i = 1'b1;
        if (clr_d) strobe_f.d = 1'b0;
        if (set_d) strobe_f.d = 1'b1;
        if (clr_v) strobe_f.v = 1'b0;
    end

    always_comb begin
        unique case (kind)
            UPD_PULL:    nxt = unpack_flags(pull_byte);
            UPD_HW_MASK: begin
                nxt   = strobe_f;
                nxt.i = 1'b1;
            end
            UPD_STROBE:  nxt = strobe_f;
            UPD_ALU:     nxt = alu_f;
            UPD_HOLD:    nxt = cur;
            default:     nxt = cur;
        endcase
    end

endmodule

// File: rtl/psr_stack_fmt.sv
module psr_stack_fmt
    import psr_pkg::*;
(
    input  flags_t            cur,
    input  push_src_e         push_src,
    output logic [BYTE_W-1:0] push_byte
);

    logic sw_origin;

    always_comb begin
        unique case (push_src)
            SRC_PUSH_INSN: sw_origin = 1'b1;
            SRC_BREAK:     sw_origin = 1'b1;
            SRC_MASKABLE:  sw_origin = 1'b0;
            SRC_NONMASK:   sw_origin = 1'b0;
            default:       sw_origin = 1'b0;
        endcase
    end

    assign push_byte = pack_flags(cur, sw_origin);

endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
    parameter bit DEC_EN = 1'b1
) (
    input  logic mask_i,
    input  logic dec_flag,
    input  logic irq_req,
    input  logic nmi_req,
    output logic irq_take,
    output logic nmi_take,
    output logic dec_mode
);

    assign irq_take = irq_req & ~mask_i;
    assign nmi_take = nmi_req;

    generate
        if (DEC_EN) begin : g_dec_on
            assign dec_mode = dec_flag;
        end else begin : g_dec_off
            assign dec_mode = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/psr_core.sv
module psr_core
    import psr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit DEC_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    input  logic              bit_mode_i,
    input  logic              upd_n_i,
    input  logic              upd_v_i,
    input  logic              upd_z_i,
    input  logic              upd_c_i,
    input  logic              set_c_i,
    input  logic              clr_c_i,
    input  logic              set_i_i,
    input  logic              clr_i_i,
    input  logic              set_d_i,
    input  logic              clr_d_i,
    input  logic              clr_v_i,
    input  logic              push_i,
    input  logic [1:0]        push_src_i,
    output logic [7:0]        push_byte_o,
    input  logic              pull_i,
    input  logic [7:0]        pull_byte_i,
    input  logic              irq_req_i,
    input  logic              nmi_req_i,
    output logic              irq_take_o,
    output logic              nmi_take_o,
    output logic              dec_mode_o,
    output logic [7:0]        flags_o
);

    flags_t    st_q;
    flags_t    st_d;
    push_src_e src;

    assign src = push_src_e'(push_src_i);

    psr_next #(.DATA_W(DATA_W)) u_next (
        .cur       (st_q),
        .res       (res_i),
        .opnd      (opnd_i),
        .carry     (carry_i),
        .ovf       (ovf_i),
        .bit_mode  (bit_mode_i),
        .upd_n     (upd_n_i),
        .upd_v     (upd_v_i),
        .upd_z     (upd_z_i),
        .upd_c     (upd_c_i),
        .set_c     (set_c_i),
        .clr_c     (clr_c_i),
        .set_i     (set_i_i),
        .clr_i     (clr_i_i),
        .set_d     (set_d_i),
        .clr_d     (clr_d_i),
        .clr_v     (clr_v_i),
        .push      (push_i),
        .push_src  (src),
        .pull      (pull_i),
        .pull_byte (pull_byte_i),
        .nxt       (st_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= FLAGS_RESET;
        else
            st_q <= st_d;
    end

    psr_stack_fmt u_fmt (
        .cur       (st_q),
        .push_src  (src),
        .push_byte (push_byte_o)
    );

    psr_irq_gate #(.DEC_EN(DEC_EN)) u_gate (
        .mask_i   (st_q.i),
        .dec_flag (st_q.d),
        .irq_req  (irq_req_i),
        .nmi_req  (nmi_req_i),
        .irq_take (irq_take_o),
        .nmi_take (nmi_take_o),
        .dec_mode (dec_mode_o)
    );

    assign flags_o = pack_flags(st_q, 1'b1);

    logic quiet;
    assign quiet = !pull_i && !push_i && !upd_n_i && !upd_v_i && !upd_z_i && !upd_c_i
                 && !set_c_i && !clr_c_i && !set_i_i && !clr_i_i && !set_d_i && !clr_d_i
                 && !clr_v_i;

    AST_PULL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        pull_i |=> (flags_o[7:6] == $past(pull_byte_i[7:6])) &&
                   (flags_o[3:0] == $past(pull_byte_i[3:0])) &&
                   (flags_o[5:4] == 2'b11)); // R4

    AST_HW_PUSH_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pull_i && push_src_i != 2'd0) |=> flags_o[POS_I]); // R3

    AST_PUSH_ORIGIN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (push_byte_o[POS_U] && (push_byte_o[POS_B] == !push_src_i[1]))); // R2

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |-> (irq_req_i && !flags_o[POS_I])); // R5

    AST_NMI_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_i |-> nmi_take_o); // R5

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(flags_o)); // R7

endmodule

// File: tb/psr_core_test.sv
module psr_core_test;
    import psr_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] res_i, opnd_i, pull_byte_i, push_byte_o, flags_o;
    logic       carry_i, ovf_i, bit_mode_i;
    logic       upd_n_i, upd_v_i, upd_z_i, upd_c_i;
    logic       set_c_i, clr_c_i, set_i_i, clr_i_i, set_d_i, clr_d_i, clr_v_i;
    logic       push_i, pull_i, irq_req_i, nmi_req_i;
    logic [1:0] push_src_i;
    logic       irq_take_o, nmi_take_o, dec_mode_o;

    always #4 clk = ~clk;

    psr_core uut (.*);

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] m;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        {res_i, opnd_i, pull_byte_i} = '0;
        {carry_i, ovf_i, bit_mode_i, upd_n_i, upd_v_i, upd_z_i, upd_c_i} = '0;
        {set_c_i, clr_c_i, set_i_i, clr_i_i, set_d_i, clr_d_i, clr_v_i} = '0;
        {push_i, pull_i, irq_req_i, nmi_req_i} = '0;
        push_src_i = 2'd0;
    endtask

    task automatic model_update();
        logic [7:0] n;
        if (pull_i) begin
            m = {pull_byte_i[7:6], 2'b11, pull_byte_i[3:0]};
        end else begin
            n = m;
            if (upd_n_i) n[7] = bit_mode_i ? opnd_i[7] : res_i[7];
            if (upd_v_i) n[6] = bit_mode_i ? opnd_i[6] : ovf_i;
            if (upd_z_i) n[1] = (res_i == 8'h00);
            if (upd_c_i) n[0] = carry_i;
            if (clr_c_i) n[0] = 1'b0;
            if (set_c_i) n[0] = 1'b1;
            if (clr_i_i) n[2] = 1'b0;
            if (set_i_i) n[2] = 1'b1;
            if (clr_d_i) n[3] = 1'b0;
            if (set_d_i) n[3] = 1'b1;
            if (clr_v_i) n[6] = 1'b0;
            if (push_i && push_src_i != 2'd0) n[2] = 1'b1;
            m = n;
        end
    endtask

    // one clock: model follows the registered update, flags compared after the edge
    task automatic tick();
        string tag;
        if (pull_i)                            tag = "R4 pull";
        else if (push_i && push_src_i != 2'd0) tag = "R3 hw/break push masks";
        else if (push_i)                       tag = "R3 push-status holds";
        else if (set_c_i | clr_c_i | set_i_i | clr_i_i | set_d_i | clr_d_i | clr_v_i)
                                               tag = "R8 set/clear";
        else if (bit_mode_i)                   tag = "R6 bit test";
        else if (upd_n_i | upd_z_i)            tag = "R6 N/Z load";
        else                                   tag = "R7 C/V load or hold";
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(tag, flags_o, m);
    endtask

    // combinational outputs against the model, inputs already applied
    task automatic comb_checks();
        #1;
        if (push_i)
            check("R2 push byte", push_byte_o,
                  {m[7:6], 1'b1, (push_src_i < 2'd2), m[3:0]});
        check("R5 maskable gate", {7'b0, irq_take_o}, {7'b0, irq_req_i & ~m[2]});
        check("R5 non-maskable pass", {7'b0, nmi_take_o}, {7'b0, nmi_req_i});
        check("R9 decimal output", {7'b0, dec_mode_o}, {7'b0, m[3]});
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        m = 8'h34;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset value", flags_o, 8'h34);

        // R5: mask holds maskable requests, non-maskable passes
        irq_req_i = 1'b1; nmi_req_i = 1'b1;
        comb_checks();
        check("R5 masked after reset", {7'b0, irq_take_o}, 8'h00);
        clr_i_i = 1'b1;
        tick();
        idle_inputs(); irq_req_i = 1'b1;
        comb_checks();
        check("R5 open after clear", {7'b0, irq_take_o}, 8'h01);

        // R2: each push source with every flag set
        idle_inputs(); pull_i = 1'b1; pull_byte_i = 8'hCF; tick();
        for (int s = 0; s < 4; s++) begin
            idle_inputs(); push_i = 1'b1; push_src_i = 2'(s);
            comb_checks();
            tick();
        end
        check("R2 break push byte", {m[7:6], 2'b11, m[3:0]}, 8'hFF);

        // R4: pseudo-bits ignored on pull, pull beats ALU loads
        idle_inputs(); pull_i = 1'b1; pull_byte_i = 8'h30;
        upd_n_i = 1'b1; upd_z_i = 1'b1; upd_c_i = 1'b1; carry_i = 1'b1; set_i_i = 1'b1;
        tick();
        check("R4 zero byte restored", flags_o, 8'h30);

        // R3: clear-mask in the same cycle as a maskable push
        idle_inputs(); push_i = 1'b1; push_src_i = 2'd2; clr_i_i = 1'b1; tick();
        check("R3 mask wins over clear", {7'b0, flags_o[2]}, 8'h01);

        // R6: bit test takes N, V from operand, Z from result
        idle_inputs(); bit_mode_i = 1'b1; upd_n_i = 1'b1; upd_v_i = 1'b1; upd_z_i = 1'b1;
        opnd_i = 8'hC0; res_i = 8'h00; tick();
        check("R6 bit test N V Z", flags_o & 8'hC2, 8'hC2);

        // R8: set and clear together, set wins; strobe beats ALU load
        idle_inputs(); set_c_i = 1'b1; clr_c_i = 1'b1; upd_c_i = 1'b1; carry_i = 1'b0;
        set_d_i = 1'b1; tick();
        check("R8 set wins", {6'b0, flags_o[3], flags_o[0]}, 8'h03);
        idle_inputs(); comb_checks();

        // randomized traffic compared each clock
        for (int k = 0; k < 600; k++) begin
            idle_inputs();
            res_i       = ($urandom_range(0, 7) == 0) ? 8'h00 : 8'($urandom);
            opnd_i      = 8'($urandom);
            pull_byte_i = 8'($urandom);
            carry_i     = 1'($urandom);
            ovf_i       = 1'($urandom);
            bit_mode_i  = ($urandom_range(0, 3) == 0);
            upd_n_i     = 1'($urandom);
            upd_v_i     = 1'($urandom);
            upd_z_i     = 1'($urandom);
            upd_c_i     = 1'($urandom);
            set_c_i     = ($urandom_range(0, 7) == 0);
            clr_c_i     = ($urandom_range(0, 7) == 0);
            set_i_i     = ($urandom_range(0, 7) == 0);
            clr_i_i     = ($urandom_range(0, 5) == 0);
            set_d_i     = ($urandom_range(0, 7) == 0);
            clr_d_i     = ($urandom_range(0, 7) == 0);
            clr_v_i     = ($urandom_range(0, 7) == 0);
            push_i      = ($urandom_range(0, 3) == 0);
            push_src_i  = 2'($urandom);
            pull_i      = ($urandom_range(0, 7) == 0);
            irq_req_i   = 1'($urandom);
            nmi_req_i   = 1'($urandom);
            comb_checks();
            tick();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule